// File: doc/BRIEF.md
# Intermittent Cycle-Steal DMA Pacer with Repeat Reload

This block sits between the per-channel DMA request logic and the external bus interface. It issues a grant-allowed level that the channel logic must see high before it starts a transfer on the external bus. A 2-bit pacing mode, held in a small operation register, can throttle starts to one per 16 or one per 64 external bus clocks. The pacing interval is counted in external bus clock enables, not core clocks. Pacing applies only while every channel is set to cycle-steal; a single channel in burst mode turns it off.

The same block holds one initial-address word per channel. A channel can run in repeat mode. When such a channel reports that its transfer sequence is complete, the block reads the stored word back and presents it as a reload for the channel's source or destination address. On every write the stored word is checked against the channel's transfer size. A misaligned write is flagged, and reloads for that channel stop until a correctly aligned word is written.

Top module: `dma_steal_pacer`

## Requirements
- R1: After reset, grant_ok is 1, cfg_err is 0, align_err is 0, rld_valid is 0 and op_rdata is 0.
- R2: With mode 00 (normal), grant_ok stays 1 after every transfer start.
- R3: With mode 10 and all chan_steal bits set to 1, an accepted start (xfer_start high while grant_ok is 1) drives grant_ok to 0 on the next cycle. grant_ok returns to 1 on the cycle after the edge that samples the 16th bus_ce. Only bus_ce values on edges after the start edge are counted.
- R4: With mode 11 and all channels in cycle-steal, the same rule as R3 applies with 64 bus_ce pulses.
- R5: Mode 01 is reserved. Writing it sets cfg_err to 1 on the next cycle, and starts are not paced. Writing any other mode clears cfg_err.
- R6: If any chan_steal bit is 0 (burst mode), a start leaves grant_ok at 1 whatever the mode.
- R7: A mode write made during a paced interval does not change that interval's length. It applies from the next accepted start.
- R8: xfer_start while grant_ok is 0 is ignored: the interval still ends after the original bus_ce count.
- R9: The mode sits in bits [1:0] of the operation register. Bits [31:2] always read 0, and whatever is written to them is dropped.
- R10: When chan_done and chan_rpt are both 1 for a channel with a valid stored address, the next cycle shows rld_valid=1 with rld_ch, rld_to_dst (taken from chan_to_dst) and rld_addr equal to the stored word.
- R11: Size codes are 00 byte, 01 16-bit, 10 32-bit and 11 16-byte unit. The required address alignment is 1, 2 or 4 bytes for the first three. For code 11 it is 16 bytes when the reload target is the source and 4 bytes when it is the destination. A misaligned write pulses align_err on the next cycle and suppresses that channel's reload until an aligned write.
- R12: A channel with chan_rpt=0 produces no reload when it completes.
- R13: When several channels complete in the same cycle, the lowest-numbered eligible channel is reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce | input | 1 | One-cycle enable per external bus clock |
| chan_steal | input | NCH | Per channel: 1 cycle-steal, 0 burst |
| xfer_start | input | 1 | A transfer starts on the external bus this cycle |
| grant_ok | output | 1 | A transfer may start |
| op_we | input | 1 | Operation register write strobe |
| op_wdata | input | 32 | Operation register write data |
| op_rdata | output | 32 | Operation register contents |
| cfg_err | output | 1 | Reserved mode selected |
| iar_we | input | 1 | Initial-address write strobe |
| iar_ch | input | CHW | Channel addressed by the write |
| iar_wdata | input | AW | Initial address to store |
| chan_size | input | 2*NCH | Per-channel transfer size code |
| chan_to_dst | input | NCH | Per channel: reload targets destination (1) or source (0) |
| chan_rpt | input | NCH | Per-channel repeat enable |
| chan_done | input | NCH | Per-channel sequence-complete pulse |
| align_err | output | 1 | Last initial-address write was misaligned |
| rld_valid | output | 1 | Reload presented this cycle |
| rld_ch | output | CHW | Channel being reloaded |
| rld_to_dst | output | 1 | Reload targets the destination address |
| rld_addr | output | AW | Address to reload |

## Verification
The pacing tests count bus_ce pulses one at a time and sample grant_ok at the 15th and 16th pulse (and at the 63rd and 64th). A counter that also counted the enable on the start edge, or counted core clocks, fails at one of those points. A stray start in the middle of an interval must not restart the count, and a mode change during an interval must not shorten or lengthen it. The bench also covers the reserved mode, a single burst channel, and misaligned 16-byte source and destination writes. A design that applied the 16-byte rule to the destination, or kept reloading a stale address after a bad write, would produce a reload where none is expected.

// File: rtl/dma_pace_pkg.sv
package dma_pace_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_RSVD   = 2'b01,
    PM_GAP16  = 2'b10,
    PM_GAP64  = 2'b11
  } pace_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_BLK16 = 2'b11
  } xfer_size_e;

  // Alignment rule for a stored initial address, by size and reload target.
  function automatic logic addr_aligned(input logic [3:0] lo,
                                        input xfer_size_e sz,
                                        input logic to_dst);
    logic ok;
    case (sz)
      SZ_BYTE:  ok = 1'b1;
      SZ_HALF:  ok = (lo[0] == 1'b0);
      SZ_WORD:  ok = (lo[1:0] == 2'b00);
      default:  ok = to_dst ? (lo[1:0] == 2'b00) : (lo == 4'h0);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dma_pace_timer.sv
module dma_pace_timer
  import dma_pace_pkg::*;
#(
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_ce,
  input  logic       xfer_start,
  input  logic       all_steal,
  input  pace_mode_e mode,
  output logic       grant_ok
);
  localparam int CW = (LONG_GAP > 2) ? $clog2(LONG_GAP) : 1;

  logic          busy_q;
  logic          gnt_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;
  logic          paced;

  // The mode bit 1 distinguishes the two paced modes from normal/reserved.
  assign paced = all_steal && mode[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      gnt_q  <= 1'b1;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (xfer_start && paced) begin
        busy_q <= 1'b1;
        gnt_q  <= 1'b0;
        cnt_q  <= '0;
        last_q <= (mode == PM_GAP64) ? CW'(LONG_GAP - 1) : CW'(SHORT_GAP - 1);
      end
    end else if (bus_ce) begin
      if (cnt_q == last_q) begin
        busy_q <= 1'b0;
        gnt_q  <= 1'b1;
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign grant_ok = gnt_q;

endmodule

// File: rtl/dma_iar_bank.sv
module dma_iar_bank
  import dma_pace_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iar_we,
  input  logic [CHW-1:0]   iar_ch,
  input  logic [AW-1:0]    iar_wdata,
  input  logic [2*NCH-1:0] chan_size,
  input  logic [NCH-1:0]   chan_to_dst,
  input  logic [NCH-1:0]   chan_rpt,
  input  logic [NCH-1:0]   chan_done,
  output logic             align_err,
  output logic             rld_valid,
  output logic [CHW-1:0]   rld_ch,
  output logic             rld_to_dst,
  output logic [AW-1:0]    rld_addr
);
  logic [AW-1:0]  mem [NCH];
  logic [NCH-1:0] vld_q;
  logic [NCH-1:0] req;
  logic [CHW-1:0] pick;
  logic           hit;
  logic           wr_ok;
  xfer_size_e     wr_sz;

  assign wr_sz = xfer_size_e'(chan_size[{iar_ch, 1'b0} +: 2]);
  assign wr_ok = addr_aligned(iar_wdata[3:0], wr_sz, chan_to_dst[iar_ch]);

  // Storage written only on aligned data; no reset so it maps to RAM.
  always_ff @(posedge clk) begin
    if (iar_we && wr_ok) mem[iar_ch] <= iar_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= '0;
      align_err <= 1'b0;
    end else begin
      align_err <= iar_we && !wr_ok;
      if (iar_we) vld_q[iar_ch] <= wr_ok;
    end
  end

  assign req = chan_done & chan_rpt & vld_q;
  assign hit = |req;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) pick = CHW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (hit) rld_addr <= mem[pick];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_valid  <= 1'b0;
      rld_ch     <= '0;
      rld_to_dst <= 1'b0;
    end else begin
      rld_valid <= hit;
      if (hit) begin
        rld_ch     <= pick;
        rld_to_dst <= chan_to_dst[pick];
      end
    end
  end

endmodule

// File: rtl/dma_steal_pacer.sv
module dma_steal_pacer
  import dma_pace_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 32,
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_ce,
  input  logic [NCH-1:0]   chan_steal,
  input  logic             xfer_start,
  output logic             grant_ok,
  input  logic             op_we,
  input  logic [31:0]      op_wdata,
  output logic [31:0]      op_rdata,
  output logic             cfg_err,
  input  logic             iar_we,
  input  logic [CHW-1:0]   iar_ch,
  input  logic [AW-1:0]    iar_wdata,
  input  logic [2*NCH-1:0] chan_size,
  input  logic [NCH-1:0]   chan_to_dst,
  input  logic [NCH-1:0]   chan_rpt,
  input  logic [NCH-1:0]   chan_done,
  output logic             align_err,
  output logic             rld_valid,
  output logic [CHW-1:0]   rld_ch,
  output logic             rld_to_dst,
  output logic [AW-1:0]    rld_addr
);
  pace_mode_e mode_q;
  logic       cfg_err_q;
  logic       unused_op_bits;

  assign unused_op_bits = ^op_wdata[31:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PM_NORMAL;
      cfg_err_q <= 1'b0;
    end else if (op_we) begin
      mode_q    <= pace_mode_e'(op_wdata[1:0]);
      cfg_err_q <= (op_wdata[1:0] == PM_RSVD);
    end
  end

  assign op_rdata = {30'b0, mode_q};
  assign cfg_err  = cfg_err_q;

  dma_pace_timer #(
    .SHORT_GAP (SHORT_GAP),
    .LONG_GAP  (LONG_GAP)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .bus_ce     (bus_ce),
    .xfer_start (xfer_start),
    .all_steal  (&chan_steal),
    .mode       (mode_q),
    .grant_ok   (grant_ok)
  );

  dma_iar_bank #(
    .NCH (NCH),
    .AW  (AW)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .iar_we      (iar_we),
    .iar_ch      (iar_ch),
    .iar_wdata   (iar_wdata),
    .chan_size   (chan_size),
    .chan_to_dst (chan_to_dst),
    .chan_rpt    (chan_rpt),
    .chan_done   (chan_done),
    .align_err   (align_err),
    .rld_valid   (rld_valid),
    .rld_ch      (rld_ch),
    .rld_to_dst  (rld_to_dst),
    .rld_addr    (rld_addr)
  );

endmodule

// File: rtl/dma_steal_pacer_chk.sv
module dma_steal_pacer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_ce,
  input logic [NCH-1:0] chan_steal,
  input logic           xfer_start,
  input logic           grant_ok,
  input logic [31:0]    op_rdata,
  input logic           cfg_err,
  input logic           iar_we,
  input logic [NCH-1:0] chan_rpt,
  input logic [NCH-1:0] chan_done,
  input logic           align_err,
  input logic           rld_valid
);
  // R1: state just after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (grant_ok && !cfg_err && !align_err && !rld_valid));

  // R3: grant can only drop right after a start
  a_r3_drop_on_start: assert property (@(posedge clk) disable iff (rst)
    $fell(grant_ok) |-> $past(xfer_start));

  // R8: grant can only return on a bus clock enable
  a_r8_rise_on_ce: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_ok) |-> $past(bus_ce));

  // R6: a burst channel bypasses pacing
  a_r6_burst_bypass: assert property (@(posedge clk) disable iff (rst)
    (grant_ok && xfer_start && !(&chan_steal)) |=> grant_ok);

  // R2 / R5: normal or reserved mode never paces
  a_r5_unpaced_modes: assert property (@(posedge clk) disable iff (rst)
    (grant_ok && xfer_start && !op_rdata[1]) |=> grant_ok);

  // R5: config error tracks the reserved code
  a_r5_cfg_err: assert property (@(posedge clk) disable iff (rst)
    cfg_err == (op_rdata[1:0] == 2'b01));

  // R9: reserved bits read zero
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    op_rdata[31:2] == 30'b0);

  // R10: a reload needs a repeat-enabled completion
  a_r10_reload_cause: assert property (@(posedge clk) disable iff (rst)
    rld_valid |-> $past(|(chan_done & chan_rpt)));

  // R11: alignment error only follows a write
  a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
    align_err |-> $past(iar_we));

endmodule

bind dma_steal_pacer dma_steal_pacer_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_ce     (bus_ce),
  .chan_steal (chan_steal),
  .xfer_start (xfer_start),
  .grant_ok   (grant_ok),
  .op_rdata   (op_rdata),
  .cfg_err    (cfg_err),
  .iar_we     (iar_we),
  .chan_rpt   (chan_rpt),
  .chan_done  (chan_done),
  .align_err  (align_err),
  .rld_valid  (rld_valid)
);

// File: tb/dma_steal_pacer_test.sv
`timescale 1ns/1ps
module dma_steal_pacer_test;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CHW = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             bus_ce;
  logic [NCH-1:0]   chan_steal;
  logic             xfer_start;
  logic             grant_ok;
  logic             op_we;
  logic [31:0]      op_wdata;
  logic [31:0]      op_rdata;
  logic             cfg_err;
  logic             iar_we;
  logic [CHW-1:0]   iar_ch;
  logic [AW-1:0]    iar_wdata;
  logic [2*NCH-1:0] chan_size;
  logic [NCH-1:0]   chan_to_dst;
  logic [NCH-1:0]   chan_rpt;
  logic [NCH-1:0]   chan_done;
  logic             align_err;
  logic             rld_valid;
  logic [CHW-1:0]   rld_ch;
  logic             rld_to_dst;
  logic [AW-1:0]    rld_addr;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  dma_steal_pacer #(.NCH(NCH), .AW(AW)) uut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [31:0] v);
    op_we = 1'b1; op_wdata = v; tick(); op_we = 1'b0; op_wdata = '0;
  endtask

  task automatic wr_iar(input int ch, input logic [31:0] a);
    iar_we = 1'b1; iar_ch = CHW'(ch); iar_wdata = a; tick(); iar_we = 1'b0;
  endtask

  // One paced interval of n bus enables; optional stray start and mode write.
  task automatic pace_run(input string tag, input int n, input int stray_at,
                          input int mode_at, input logic [31:0] new_mode);
    xfer_start = 1'b1; bus_ce = 1'b1; tick();
    xfer_start = 1'b0; bus_ce = 1'b0;
    chk({tag, " grant low after start"}, grant_ok, 0);
    for (int k = 1; k <= n; k++) begin
      bus_ce = 1'b1; tick(); bus_ce = 1'b0;
      if (k == n - 1) chk({tag, " grant still low one before end"}, grant_ok, 0);
      if (k == n)     chk({tag, " grant back at end"}, grant_ok, 1);
      if (k == stray_at) begin
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
      end
      if (k == mode_at) wr_op(new_mode);
      tick();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
    chk("R1 grant_ok", grant_ok, 1);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 align_err", align_err, 0);
    chk("R1 rld_valid", rld_valid, 0);
    chk("R1 op_rdata", op_rdata, 0);
  endtask

  task automatic t_normal();
    wr_op(32'h0);
    for (int i = 0; i < 3; i++) begin
      xfer_start = 1'b1; tick(); xfer_start = 1'b0;
      chk("R2 normal mode no pacing", grant_ok, 1);
    end
  endtask

  task automatic t_gap16();
    wr_op(32'h2);
    pace_run("R3 gap16", 16, 0, 0, 0);
  endtask

  task automatic t_stray();
    pace_run("R8 stray start ignored", 16, 5, 0, 0);
  endtask

  task automatic t_mode_change();
    pace_run("R7 interval keeps length", 16, 0, 3, 32'h3);
    pace_run("R4 gap64 after change", 64, 0, 0, 0);
  endtask

  task automatic t_rsvd();
    wr_op(32'h1);
    chk("R5 cfg_err set", cfg_err, 1);
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    chk("R5 reserved unpaced", grant_ok, 1);
    wr_op(32'h2);
    chk("R5 cfg_err cleared", cfg_err, 0);
  endtask

  task automatic t_burst();
    wr_op(32'h3);
    chan_steal = 4'b1011;
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    chk("R6 burst channel bypass", grant_ok, 1);
    chan_steal = 4'hF;
  endtask

  task automatic t_opreg();
    wr_op(32'hFFFF_FFF2);
    chk("R9 reserved bits dropped", op_rdata, 32'h2);
    wr_op(32'hA5A5_A5A7);
    chk("R9 mode field only", op_rdata, 32'h3);
    wr_op(32'h0);
  endtask

  task automatic t_reload();
    // ch3..ch0 sizes: blk16, blk16, 16-bit, 32-bit; ch1 and ch3 reload destination
    chan_size = {2'b11, 2'b11, 2'b01, 2'b10};
    chan_to_dst = 4'b1010;
    chan_rpt = 4'hF;
    wr_iar(0, 32'h1000_0004); chk("R11 ch0 aligned", align_err, 0);
    wr_iar(1, 32'h2000_0002); chk("R11 ch1 aligned", align_err, 0);
    wr_iar(2, 32'h3000_0010); chk("R11 ch2 aligned", align_err, 0);
    wr_iar(3, 32'h4000_0024); chk("R11 ch3 dst 4-byte ok", align_err, 0);
    chan_done = 4'b0001; tick(); chan_done = '0;
    chk("R10 valid ch0", rld_valid, 1);
    chk("R10 ch0 index", rld_ch, 0);
    chk("R10 ch0 target", rld_to_dst, 0);
    chk("R10 ch0 addr", rld_addr, 32'h1000_0004);
    tick();
    chk("R10 valid drops", rld_valid, 0);
    chan_done = 4'b0010; tick(); chan_done = '0;
    chk("R10 ch1 target dst", rld_to_dst, 1);
    chk("R10 ch1 addr", rld_addr, 32'h2000_0002);
    chan_done = 4'b1100; tick(); chan_done = '0;
    chk("R13 lowest wins ch", rld_ch, 2);
    chk("R13 lowest wins addr", rld_addr, 32'h3000_0010);
    chan_rpt = 4'b1110;
    chan_done = 4'b0001; tick(); chan_done = '0;
    chk("R12 no repeat no reload", rld_valid, 0);
    chan_rpt = 4'hF;
  endtask

  task automatic t_align();
    wr_iar(0, 32'h1000_0006); chk("R11 ch0 32-bit misaligned", align_err, 1);
    chan_done = 4'b0001; tick(); chan_done = '0;
    chk("R11 ch0 reload suppressed", rld_valid, 0);
    wr_iar(2, 32'h3000_0008); chk("R11 ch2 src 16-byte misaligned", align_err, 1);
    wr_iar(1, 32'h2000_0003); chk("R11 ch1 16-bit misaligned", align_err, 1);
    wr_iar(3, 32'h4000_0008); chk("R11 ch3 dst blk16 ok", align_err, 0);
    chan_done = 4'b1101; tick(); chan_done = '0;
    chk("R11 only ch3 eligible", rld_ch, 3);
    chk("R11 ch3 new addr", rld_addr, 32'h4000_0008);
    wr_iar(0, 32'h1000_0008); chk("R11 ch0 rewritten ok", align_err, 0);
    chan_done = 4'b0001; tick(); chan_done = '0;
    chk("R11 ch0 reload restored", rld_addr, 32'h1000_0008);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_ce = 1'b0; chan_steal = 4'hF; xfer_start = 1'b0;
    op_we = 1'b0; op_wdata = '0; iar_we = 1'b0; iar_ch = '0; iar_wdata = '0;
    chan_size = '0; chan_to_dst = '0; chan_rpt = '0; chan_done = '0;
    t_reset();
    t_normal();
    t_gap16();
    t_stray();
    t_mode_change();
    t_rsvd();
    t_burst();
    t_opreg();
    t_reload();
    t_align();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule